// File: doc/BRIEF.md
# Shadowed Clock Divider Bank

This block produces seven divided clock enables for one display channel from a single source clock. The enables serve the VGA, picture, TV encoder, HDMI pixel-rate, HDMI, interface and layer domains. Each domain has a 3-bit divide ratio. Software writes the ratios one at a time through a small write port into a staging (shadow) copy. The running dividers do not see those writes until software commits them.

Software commits by raising an update flag. The expected sequence is: drive the flag low, write any number of ratios, then drive the flag high. On the cycle the flag rises, every staged ratio moves into the active set at once. Each divider then finishes the period it is in and starts its next period with the new ratio. A changed ratio therefore never produces a shortened enable period.

A ratio value N gives one enable pulse every N+1 source cycles, so 0 passes the source rate straight through. The muxing of real clocks and any PLL sit outside this block.

Top module: `clkdiv_bank`

## Requirements
- R1: While rst_n is low at a clock edge, every staged and active ratio clears to 0 and every divider counter clears to 0. From the first cycle after reset, all seven bits of div_tick are 1.
- R2: A cycle with wr_en=1 and wr_id in 0..6 stores wr_ratio as the staged ratio of that one divider. The other staged ratios keep their values. Divider numbering: 0 VGA, 1 picture, 2 TV encoder, 3 HDMI pixel-rate, 4 HDMI, 5 interface, 6 layer; div_tick bit i belongs to divider i.
- R3: A write with wr_id=7 changes no staged ratio. After a later commit, every div_tick bit keeps the period it would have had without that write.
- R4: Staged writes have no effect on div_tick until a commit.
- R5: A commit happens only in a cycle where upd_flag is 1 and was 0 in the previous cycle. The flag held high, or the flag falling, commits nothing.
- R6: A commit copies all seven staged ratios into the active set in the same cycle. A write in the commit cycle itself is part of what gets committed.
- R7: A divider with active ratio N asserts its div_tick bit for one cycle out of every N+1. With N=0 the bit stays high.
- R8: A divider picks up its ratio only when its count reaches terminal (div_tick high). A new ratio first governs the period that starts at or after the commit, and an ongoing period is never cut short.
- R9: All seven dividers change ratio from the same commit. None of them uses a mix of old and new staged values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Write strobe for the staging registers |
| wr_id | input | 3 | Divider identifier (0..6 valid, 7 ignored) |
| wr_ratio | input | 3 | Ratio value N (divide by N+1) |
| upd_flag | input | 1 | Update flag; a rising level commits the staged ratios |
| div_tick | output | 7 | One clock enable per divider |

## Verification
Three things can land in the same cycle: a staging write, a commit, and a divider's terminal count. The bench writes a ratio in the very cycle upd_flag rises. It also sweeps the commit across every cycle offset of a running period, so that some commits coincide with a terminal count and some do not. A cycle-level model built from the requirements predicts every div_tick bit on every cycle. Each mismatch is tagged with the requirement the current phase exercises.

// File: rtl/clkdiv_pkg.sv
// Package: shared constants and the divider numbering for the divider bank.
// Assumes one bank serves exactly one display channel.
package clkdiv_pkg;

    localparam int unsigned DIV_COUNT = 7;
    localparam int unsigned RATIO_W   = 3;
    localparam int unsigned ID_W      = 3;

    typedef enum logic [ID_W-1:0] {
        DIV_VGA      = 3'd0,
        DIV_PICTURE  = 3'd1,
        DIV_TV_ENC   = 3'd2,
        DIV_HDMI_PXL = 3'd3,
        DIV_HDMI     = 3'd4,
        DIV_IFACE    = 3'd5,
        DIV_LAYER    = 3'd6
    } div_id_e;

endpackage

// File: rtl/clkdiv_shadow.sv
// Module: staging registers for the divide ratios.
// One field per divider. A write whose id matches no divider changes nothing.
// shadow_next shows the staged set including the write of the current cycle,
// so a commit in the same cycle can take that write along.
module clkdiv_shadow #(
    parameter int unsigned NUM_DIV = 7,
    parameter int unsigned RATIO_W = 3,
    parameter int unsigned ID_W    = 3
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_en,
    input  logic [ID_W-1:0]                  wr_id,
    input  logic [RATIO_W-1:0]               wr_ratio,
    output logic [NUM_DIV-1:0][RATIO_W-1:0]  shadow_q,
    output logic [NUM_DIV-1:0][RATIO_W-1:0]  shadow_next
);

    for (genvar d = 0; d < NUM_DIV; d++) begin : g_field
        localparam logic [ID_W-1:0] MY_ID = ID_W'(d);

        // Purpose: merge a matching write into this field.
        always_comb begin
            shadow_next[d] = shadow_q[d];
            if (wr_en && (wr_id == MY_ID)) begin
                shadow_next[d] = wr_ratio;
            end
        end

        // Purpose: hold the staged ratio; reset to pass-through.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_q[d] <= '0;
            end else begin
                shadow_q[d] <= shadow_next[d];
            end
        end
    end

endmodule

// File: rtl/clkdiv_commit.sv
// Module: turns the update flag into a one-cycle commit strobe.
// Assumes upd_flag is synchronous to clk. Only a 0-to-1 change commits.
module clkdiv_commit (
    input  logic clk,
    input  logic rst_n,
    input  logic upd_flag,
    output logic commit
);

    logic flag_prev;

    // Purpose: remember the flag level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_prev <= 1'b0;
        end else begin
            flag_prev <= upd_flag;
        end
    end

    // Purpose: strobe on the rising level only.
    always_comb begin
        commit = upd_flag && !flag_prev;
    end

endmodule

// File: rtl/clkdiv_counter.sv
// Module: one down-counting divider.
// The tick is high while the count is zero. At that point the counter
// reloads from reload_ratio, so a new ratio only starts at a period
// boundary and never truncates a period.
module clkdiv_counter #(
    parameter int unsigned RATIO_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [RATIO_W-1:0] reload_ratio,
    output logic               tick
);

    logic [RATIO_W-1:0] count_q;

    // Purpose: terminal count flags the enable.
    always_comb begin
        tick = (count_q == '0);
    end

    // Purpose: count down; reload at terminal.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (tick) begin
            count_q <= reload_ratio;
        end else begin
            count_q <= count_q - 1'b1;
        end
    end

endmodule

// File: rtl/clkdiv_bank.sv
// Module: top of the shadowed divider bank.
// Ratios are staged by clkdiv_shadow and copied as a set into the active
// registers on a commit strobe. Each clkdiv_counter reloads from the value
// the active set holds after this cycle, so a commit that falls on a
// terminal count governs the very next period.
module clkdiv_bank
    import clkdiv_pkg::*;
#(
    parameter int unsigned NUM_DIV = DIV_COUNT,
    parameter int unsigned RW      = RATIO_W,
    parameter int unsigned IW      = ID_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IW-1:0]      wr_id,
    input  logic [RW-1:0]      wr_ratio,
    input  logic               upd_flag,
    output logic [NUM_DIV-1:0] div_tick
);

    logic [NUM_DIV-1:0][RW-1:0] shadow_q;
    logic [NUM_DIV-1:0][RW-1:0] shadow_next;
    logic [NUM_DIV-1:0][RW-1:0] active_q;
    logic [NUM_DIV-1:0][RW-1:0] active_next;
    logic                       commit;

    clkdiv_shadow #(
        .NUM_DIV (NUM_DIV),
        .RATIO_W (RW),
        .ID_W    (IW)
    ) u_shadow (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_id       (wr_id),
        .wr_ratio    (wr_ratio),
        .shadow_q    (shadow_q),
        .shadow_next (shadow_next)
    );

    clkdiv_commit u_commit (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_flag (upd_flag),
        .commit   (commit)
    );

    // Purpose: select the active set for the next cycle.
    always_comb begin
        active_next = commit ? shadow_next : active_q;
    end

    // Purpose: hold the active ratios; reset to pass-through.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= '0;
        end else begin
            active_q <= active_next;
        end
    end

    for (genvar d = 0; d < NUM_DIV; d++) begin : g_div
        clkdiv_counter #(
            .RATIO_W (RW)
        ) u_cnt (
            .clk          (clk),
            .rst_n        (rst_n),
            .reload_ratio (active_next[d]),
            .tick         (div_tick[d])
        );
    end

endmodule

// File: rtl/clkdiv_bank_chk.sv
// Module: assertion checker for clkdiv_bank, attached by bind.
module clkdiv_bank_chk #(
    parameter int unsigned NUM_DIV = 7,
    parameter int unsigned RW      = 3,
    parameter int unsigned IW      = 3
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [IW-1:0]              wr_id,
    input logic                       upd_flag,
    input logic                       commit,
    input logic [NUM_DIV-1:0][RW-1:0] shadow_q,
    input logic [NUM_DIV-1:0][RW-1:0] shadow_next,
    input logic [NUM_DIV-1:0][RW-1:0] active_q,
    input logic [NUM_DIV-1:0][RW-1:0] active_next,
    input logic [NUM_DIV-1:0]         div_tick
);

    assert_idle_keeps_shadow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(shadow_q));

    assert_bad_id_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_id) >= NUM_DIV)) |=> $stable(shadow_q));

    assert_no_commit_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(active_q));

    assert_commit_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> upd_flag);

    assert_commit_copies_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (active_q == $past(shadow_next)));

    for (genvar d = 0; d < NUM_DIV; d++) begin : g_per_div
        assert_passthru_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (div_tick[d] && (active_next[d] == '0)) |=> div_tick[d]);

        assert_no_runt_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (div_tick[d] && (active_next[d] != '0)) |=> !div_tick[d]);
    end

endmodule

bind clkdiv_bank clkdiv_bank_chk #(
    .NUM_DIV (NUM_DIV),
    .RW      (RW),
    .IW      (IW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .wr_id       (wr_id),
    .upd_flag    (upd_flag),
    .commit      (commit),
    .shadow_q    (shadow_q),
    .shadow_next (shadow_next),
    .active_q    (active_q),
    .active_next (active_next),
    .div_tick    (div_tick)
);

// File: tb/test_clkdiv_bank.sv
`timescale 1ns/1ps
module test_clkdiv_bank;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_id = '0;
    logic [2:0] wr_ratio = '0;
    logic       upd_flag = 1'b0;
    logic [6:0] div_tick;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    clkdiv_bank i_clkdiv_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_id    (wr_id),
        .wr_ratio (wr_ratio),
        .upd_flag (upd_flag),
        .div_tick (div_tick)
    );

    // Reference model from the requirements
    logic [2:0] m_sh  [7];
    logic [2:0] m_act [7];
    logic [2:0] m_cnt [7];
    logic       m_prev;

    always @(posedge clk) begin
        logic [2:0] nsh [7];
        logic [2:0] nact [7];
        if (!rst_n) begin
            for (int d = 0; d < 7; d++) begin
                m_sh[d] = '0; m_act[d] = '0; m_cnt[d] = '0;
            end
            m_prev = 1'b0;
        end else begin
            for (int d = 0; d < 7; d++) nsh[d] = m_sh[d];
            if (wr_en && wr_id < 3'd7) nsh[wr_id] = wr_ratio;
            for (int d = 0; d < 7; d++)
                nact[d] = (upd_flag && !m_prev) ? nsh[d] : m_act[d];
            for (int d = 0; d < 7; d++) begin
                if (m_cnt[d] == 3'd0) m_cnt[d] = nact[d];
                else m_cnt[d] = m_cnt[d] - 3'd1;
                m_sh[d] = nsh[d];
                m_act[d] = nact[d];
            end
            m_prev = upd_flag;
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        logic [6:0] exp;
        if (rst_n && !done) begin
            for (int d = 0; d < 7; d++) exp[d] = (m_cnt[d] == 3'd0);
            checks++;
            if (div_tick !== exp) begin
                errors++;
                $display("FAIL %s: div_tick=%b expected=%b at %0t", cur_req, div_tick, exp, $time);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put(input logic [2:0] id, input logic [2:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_id = id; wr_ratio = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic commit_now();
        @(negedge clk); upd_flag = 1'b0;
        @(negedge clk); upd_flag = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        cur_req = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (div_tick !== 7'h7f) begin
            errors++;
            $display("FAIL R1: div_tick=%b expected=%b", div_tick, 7'h7f);
        end
        idle(5);

        // R7 R9: sweep every ratio on every divider, all committed together
        cur_req = "R7 R9";
        for (int k = 0; k < 8; k++) begin
            for (int d = 0; d < 7; d++) put(3'(d), 3'((d + k) % 8));
            commit_now();
            idle(40);
        end

        // R2: a single-field write touches only that divider
        cur_req = "R2";
        for (int d = 0; d < 7; d++) begin
            put(3'(d), 3'(7 - d));
            commit_now();
            idle(20);
        end

        // R4: staged writes without commit do nothing
        cur_req = "R4";
        for (int d = 0; d < 7; d++) put(3'(d), 3'(d));
        idle(30);

        // R5: flag held high, then falling, commits nothing
        cur_req = "R5";
        put(3'd2, 3'd5);
        upd_flag = 1'b0;
        idle(20);
        commit_now();
        put(3'd3, 3'd1);
        idle(20);
        upd_flag = 1'b0;
        idle(20);

        // R3: id 7 is ignored
        cur_req = "R3";
        for (int v = 0; v < 8; v++) begin
            put(3'd7, 3'(v));
            commit_now();
            idle(12);
        end

        // R6: write in the commit cycle is committed
        cur_req = "R6";
        for (int d = 0; d < 7; d++) begin
            @(negedge clk); upd_flag = 1'b0;
            @(negedge clk);
            upd_flag = 1'b1; wr_en = 1'b1; wr_id = 3'(d); wr_ratio = 3'(d + 1);
            @(negedge clk);
            wr_en = 1'b0;
            idle(20);
        end

        // R8: commit at every offset of a running period
        cur_req = "R8";
        for (int off = 0; off < 9; off++) begin
            for (int d = 0; d < 7; d++) put(3'(d), 3'd7);
            commit_now();
            idle(3);
            for (int d = 0; d < 7; d++) put(3'(d), 3'((d + off) % 3));
            @(negedge clk); upd_flag = 1'b0;
            idle(off);
            upd_flag = 1'b1;
            idle(24);
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: phase %s not finished, actual=hung expected=done", cur_req);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule